// File: doc/BRIEF.md
# Two-Level Local History Direction Predictor

This block predicts whether a conditional branch is taken and where it goes. Each branch has a history register that holds its own recent outcomes. That history selects a saturating counter in a shared pattern table, and the counter's top bit is the direction prediction. A small tagged target store supplies the destination address. A branch that follows a repeating taken/not-taken sequence can therefore be predicted exactly, and not only by its usual direction.

The fetch stage presents a PC and reads the prediction in the same cycle. The prediction is the direction, the history value used, and the target with its hit flag. The pipeline carries the history value with the branch. When the branch resolves in execute, it presents the resolved PC, the outcome, the carried history and the resolved target for one cycle. All tables change at that clock edge.

Top module: `local_hist_pred`

## Requirements
- R1: After reset every history register reads zero, every counter is weakly not-taken, and no target entry is valid. Any fetch PC therefore gives pred_taken=0, pred_hist=0 and pred_hit=0.
- R2: The history register read for a fetch is selected by fetch_pc[HIST_IDX_W+1:2], and its value appears on pred_hist. Branches in different slots keep separate histories.
- R3: An update shifts the history entry at upd_pc[HIST_IDX_W+1:2] left by one. upd_taken (1 = taken) enters bit 0 and the oldest bit is dropped.
- R4: The pattern table has 2^HIST_W counters and is indexed by pred_hist. pred_taken is the most significant bit of the selected counter.
- R5: An update changes only the counter at upd_hist, which is the history carried from prediction time. It steps up on taken and down on not-taken and saturates at both ends. With 2-bit counters, starting from 01, one taken outcome gives a taken prediction. From 11, one not-taken outcome still predicts taken.
- R6: A taken update writes valid, tag upd_pc[PC_W-1:TGT_IDX_W+2] and upd_target into the target slot upd_pc[TGT_IDX_W+1:2]. pred_hit is 1 only when the fetch slot is valid and its tag matches, and pred_target then gives the stored target.
- R7: A fetch in the same cycle as an update sees the table contents from before that update. The change is visible from the next cycle.
- R8: A single branch that repeats a pattern with a period of up to HIST_W outcomes is predicted correctly on every occurrence once the counters have settled.
- R9: A not-taken update leaves the target store unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | PC looked up in fetch |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History value used for this prediction |
| pred_hit | output | 1 | Target store hit |
| pred_target | output | PC_W | Predicted target, meaningful when pred_hit is 1 |
| upd_en | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | HIST_W | History carried from prediction time |
| upd_target | input | PC_W | Resolved target address |

## Verification
A fetch lookup and a resolution update can fall in the same cycle, including on the same history slot, the same pattern counter and the same target slot. The bench drives that case on purpose. It fetches a branch while the same branch is being resolved, and expects the pre-update history in that cycle and the shifted history in the next. A behavioural reference model, which updates only at the clock edge, also checks every cycle of the directed and pattern-training sequences.

// File: rtl/lh_pkg.sv
package lh_pkg;
  // byte offset below the instruction word index
  localparam int unsigned WORD_LSB = 2;
endpackage

// File: rtl/lh_hist_table.sv
module lh_hist_table #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   rd_pc,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              wr_taken
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] hist_d [DEPTH];
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [HIST_W-1:0] shifted;

  assign rd_idx  = rd_pc[lh_pkg::WORD_LSB +: IDX_W];
  assign wr_idx  = wr_pc[lh_pkg::WORD_LSB +: IDX_W];
  assign rd_hist = hist_q[rd_idx];

  generate
    if (HIST_W == 1) begin : g_one
      assign shifted = wr_taken;
    end else begin : g_many
      assign shifted = {hist_q[wr_idx][HIST_W-2:0], wr_taken};
    end
  endgenerate

  always_comb begin
    hist_d = hist_q;
    hist_d[wr_idx] = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q <= hist_d;
    end
  end
endmodule

// File: rtl/lh_pattern_table.sv
module lh_pattern_table #(
  parameter int unsigned HIST_W = 4,
  parameter int unsigned CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_hist,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_hist,
  input  logic              wr_taken
);
  localparam int unsigned DEPTH = 1 << HIST_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] ctr_q [DEPTH];
  logic [CTR_W-1:0] ctr_d [DEPTH];
  logic [CTR_W-1:0] cur;

  assign rd_taken = ctr_q[rd_hist][CTR_W-1];

  always_comb begin
    ctr_d = ctr_q;
    cur   = ctr_q[wr_hist];
    if (wr_taken && cur != CTR_MAX)
      ctr_d[wr_hist] = cur + CTR_W'(1);
    else if (!wr_taken && cur != '0)
      ctr_d[wr_hist] = cur - CTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) ctr_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_q <= ctr_d;
    end
  end
endmodule

// File: rtl/lh_target_buf.sv
module lh_target_buf #(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [PC_W-1:0] rd_target,
  input  logic            wr_en,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [PC_W-1:0] wr_target
);
  localparam int unsigned DEPTH   = 1 << IDX_W;
  localparam int unsigned TAG_LSB = IDX_W + lh_pkg::WORD_LSB;
  localparam int unsigned TAG_W   = PC_W - TAG_LSB;

  logic             vld_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  assign rd_idx    = rd_pc[lh_pkg::WORD_LSB +: IDX_W];
  assign wr_idx    = wr_pc[lh_pkg::WORD_LSB +: IDX_W];
  assign rd_tag    = rd_pc[PC_W-1:TAG_LSB];
  assign wr_tag    = wr_pc[PC_W-1:TAG_LSB];
  assign rd_hit    = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_target = tgt_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) vld_q[i] <= 1'b0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_target;
    end
  end
endmodule

// File: rtl/local_hist_pred.sv
module local_hist_pred #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned HIST_IDX_W = 4,
  parameter int unsigned HIST_W     = 4,
  parameter int unsigned CTR_W      = 2,
  parameter int unsigned TGT_IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  output logic              pred_hit,
  output logic [PC_W-1:0]   pred_target,
  input  logic              upd_en,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic [PC_W-1:0]   upd_target
);
  logic tgt_wr;
  assign tgt_wr = upd_en && upd_taken;

  lh_hist_table #(.PC_W(PC_W), .IDX_W(HIST_IDX_W), .HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(fetch_pc), .rd_hist(pred_hist),
    .wr_en(upd_en), .wr_pc(upd_pc), .wr_taken(upd_taken)
  );

  lh_pattern_table #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_pat (
    .clk(clk), .rst_n(rst_n),
    .rd_hist(pred_hist), .rd_taken(pred_taken),
    .wr_en(upd_en), .wr_hist(upd_hist), .wr_taken(upd_taken)
  );

  lh_target_buf #(.PC_W(PC_W), .IDX_W(TGT_IDX_W)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(fetch_pc), .rd_hit(pred_hit), .rd_target(pred_target),
    .wr_en(tgt_wr), .wr_pc(upd_pc), .wr_target(upd_target)
  );
endmodule

// File: rtl/local_hist_pred_chk.sv
module local_hist_pred_chk #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned HIST_IDX_W = 4,
  parameter int unsigned HIST_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PC_W-1:0]   fetch_pc,
  input logic              pred_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              pred_hit,
  input logic [PC_W-1:0]   pred_target,
  input logic              upd_en,
  input logic [PC_W-1:0]   upd_pc,
  input logic              upd_taken
);
  logic seen_taken_q;
  logic same_slot;

  assign same_slot = upd_pc[HIST_IDX_W+1:2] == fetch_pc[HIST_IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_taken_q <= 1'b0;
    else if (upd_en && upd_taken) seen_taken_q <= 1'b1;
  end

  // R6
  hit_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> seen_taken_q);

  // R9
  nt_keeps_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !upd_taken) |=>
      (!$stable(fetch_pc) || ($stable(pred_hit) && $stable(pred_target))));

  // R3
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && same_slot) |=>
      (!$stable(fetch_pc) || pred_hist == {$past(pred_hist[HIST_W-2:0]), $past(upd_taken)}));

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en || !same_slot) |=>
      (!$stable(fetch_pc[HIST_IDX_W+1:2]) || $stable(pred_hist)));

  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> (!$stable(fetch_pc) || $stable(pred_taken)));
endmodule

bind local_hist_pred local_hist_pred_chk #(
  .PC_W(PC_W), .HIST_IDX_W(HIST_IDX_W), .HIST_W(HIST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
  .pred_taken(pred_taken), .pred_hist(pred_hist),
  .pred_hit(pred_hit), .pred_target(pred_target),
  .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken)
);

// File: tb/local_hist_pred_bench.sv
`timescale 1ns/1ps
module local_hist_pred_bench;
  localparam int HI = 4, HW = 4, CW = 2, BI = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0, pred_target;
  logic upd_en = 1'b0, upd_taken = 1'b0, pred_taken, pred_hit;
  logic [HW-1:0] upd_hist = '0, pred_hist;

  local_hist_pred #(.PC_W(32), .HIST_IDX_W(HI), .HIST_W(HW), .CTR_W(CW), .TGT_IDX_W(BI))
  u_local_hist_pred (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_hist(pred_hist),
    .pred_hit(pred_hit), .pred_target(pred_target),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_hist(upd_hist), .upd_target(upd_target)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int m_hist [1<<HI];
  int m_ctr  [1<<HW];
  bit m_vld  [1<<BI];
  int unsigned m_tag [1<<BI];
  logic [31:0] m_tgt [1<<BI];
  logic [HW-1:0] cap_hist;
  logic cap_taken, cap_hit;
  logic [31:0] cap_tgt;

  task automatic ck(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] fpc, input bit ue, input logic [31:0] upc,
                      input bit ut, input logic [HW-1:0] uh, input logic [31:0] utg,
                      input string req);
    int eh, bi;
    bit et, ehit;
    fetch_pc = fpc; upd_en = ue; upd_pc = upc; upd_taken = ut;
    upd_hist = uh; upd_target = utg;
    @(negedge clk);
    eh   = m_hist[(fpc >> 2) % (1<<HI)];
    et   = m_ctr[eh] >= (1 << (CW-1));
    bi   = (fpc >> 2) % (1<<BI);
    ehit = m_vld[bi] && (m_tag[bi] == (fpc >> (BI+2)));
    cap_hist = pred_hist; cap_taken = pred_taken; cap_hit = pred_hit; cap_tgt = pred_target;
    ck(pred_hist == HW'(eh), {req, " model hist"}, pred_hist, eh);
    ck(pred_taken == et && pred_hit == ehit && (!ehit || pred_target == m_tgt[bi]),
       {req, " model dir/hit/target"}, {pred_taken, pred_hit, pred_target},
       {et, ehit, (ehit ? m_tgt[bi] : pred_target)});
    @(posedge clk);
    if (ue) begin
      int hi;
      hi = (upc >> 2) % (1<<HI);
      if (ut && m_ctr[uh] < (1<<CW)-1) m_ctr[uh]++;
      if (!ut && m_ctr[uh] > 0) m_ctr[uh]--;
      m_hist[hi] = ((m_hist[hi] << 1) | int'(ut)) % (1<<HW);
      if (ut) begin
        bi = (upc >> 2) % (1<<BI);
        m_vld[bi] = 1'b1; m_tag[bi] = upc >> (BI+2); m_tgt[bi] = utg;
      end
    end
    #1;
  endtask

  task automatic run_pattern(input logic [31:0] pc, input int period, input int mask,
                             input int iters, input int warm);
    int miss = 0;
    for (int k = 0; k < iters; k++) begin
      bit outc;
      logic [HW-1:0] h;
      logic t;
      outc = (mask >> (k % period)) & 1;
      step(pc, 0, 0, 0, 0, 0, "R8");
      h = cap_hist; t = cap_taken;
      step(32'h200, 1, pc, outc, h, pc + 32'h40, "R8");
      if (k >= warm) begin
        ck(t == outc, "R8 settled prediction", t, outc);
        if (t != outc) miss++;
      end
    end
    ck(miss == 0, "R8 full accuracy", miss, 0);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<HI); i++) m_hist[i] = 0;
    for (int i = 0; i < (1<<HW); i++) m_ctr[i] = (1 << (CW-1)) - 1;
    for (int i = 0; i < (1<<BI); i++) begin m_vld[i] = 0; m_tag[i] = 0; m_tgt[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state
    step(32'h100, 0, 0, 0, 0, 0, "R1");
    ck(cap_taken == 0 && cap_hist == 0 && cap_hit == 0, "R1 reset", {cap_taken, cap_hist, cap_hit}, 0);
    step(32'hFFFF_FFFC, 0, 0, 0, 0, 0, "R1");
    ck(cap_hit == 0, "R1 no valid target", cap_hit, 0);

    // R3: two updates on 0x40, taken then not-taken
    step(32'h300, 1, 32'h40, 1, 4'h0, 32'h800, "R3");
    step(32'h300, 1, 32'h40, 0, 4'h1, 32'h0, "R3");
    step(32'h40, 0, 0, 0, 0, 0, "R3");
    ck(cap_hist == 4'b0010, "R3 shift", cap_hist, 4'b0010);
    // R2: a different slot keeps its own history
    step(32'h44, 0, 0, 0, 0, 0, "R2");
    ck(cap_hist == 4'b0000, "R2 separate slot", cap_hist, 0);
    // R4/R5: counter at pattern 0 is now 10 -> taken
    ck(cap_taken == 1, "R4 msb of counter 0", cap_taken, 1);
    step(32'h300, 1, 32'h48, 0, 4'h0, 0, "R5");
    step(32'h44, 0, 0, 0, 0, 0, "R5");
    ck(cap_taken == 0, "R5 down to weak not-taken", cap_taken, 0);
    step(32'h300, 1, 32'h48, 1, 4'h0, 32'h900, "R5");
    step(32'h300, 1, 32'h48, 1, 4'h0, 32'h900, "R5");
    step(32'h300, 1, 32'h48, 1, 4'h0, 32'h900, "R5");
    step(32'h300, 1, 32'h48, 0, 4'h0, 0, "R5");
    step(32'h44, 0, 0, 0, 0, 0, "R5");
    ck(cap_taken == 1, "R5 strong taken survives one not-taken", cap_taken, 1);
    step(32'h300, 1, 32'h48, 0, 4'h0, 0, "R5");
    step(32'h44, 0, 0, 0, 0, 0, "R5");
    ck(cap_taken == 0, "R5 second not-taken flips", cap_taken, 0);

    // R6: target store
    step(32'h40, 0, 0, 0, 0, 0, "R6");
    ck(cap_hit == 1 && cap_tgt == 32'h800, "R6 hit target", cap_tgt, 32'h800);
    step(32'h80, 0, 0, 0, 0, 0, "R6");
    ck(cap_hit == 0, "R6 tag mismatch", cap_hit, 0);
    // R9: not-taken update leaves the target store alone
    step(32'h300, 1, 32'h80, 0, 4'hF, 32'h999, "R9");
    step(32'h80, 0, 0, 0, 0, 0, "R9");
    ck(cap_hit == 0, "R9 no fill on not-taken", cap_hit, 0);
    step(32'h40, 0, 0, 0, 0, 0, "R9");
    ck(cap_hit == 1 && cap_tgt == 32'h800, "R9 entry kept", cap_tgt, 32'h800);
    ck(cap_hist == 4'b0100, "R3 alias slot shifted", cap_hist, 4'b0100);

    // R7: fetch and update of the same branch in one cycle
    step(32'h40, 1, 32'h40, 1, 4'b0100, 32'h840, "R7");
    ck(cap_hist == 4'b0100 && cap_tgt == 32'h800, "R7 old contents", cap_hist, 4'b0100);
    step(32'h40, 0, 0, 0, 0, 0, "R7");
    ck(cap_hist == 4'b1001 && cap_tgt == 32'h840, "R7 new contents next cycle", cap_hist, 4'b1001);

    // R8: repeating patterns (bit k of mask = outcome k)
    run_pattern(32'h1000_0050, 3, 3'b011, 60, 30);
    run_pattern(32'h58, 4, 4'b0001, 60, 30);
    run_pattern(32'h60, 2, 2'b01, 50, 30);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule